// File: doc/BRIEF.md
# Static Branch Policy Fetch Controller

This block is the front end of a five-stage in-order pipeline. It owns the fetch program counter and the register that hands an instruction to decode. The register holds the instruction word, its address and a valid bit. Instruction memory is a synchronous read port: the block presents an address and the word for it returns one cycle later. Decode tells the block how a branch in its stage resolves, using a resolve strobe, a taken flag and a target address. Outcome and target both become known in decode.

A one-bit policy input selects how conditional branches are handled. In the freeze policy, nothing that follows a branch is passed to decode until the branch resolves. Every branch therefore costs exactly one cycle, whatever its outcome. In the predict-not-taken policy, fetch carries on down the sequential path. An untaken branch then costs nothing. A taken branch turns the word fetched behind it into a no-op and restarts fetch at the target, losing one cycle. A squashed word never reaches decode as a valid instruction, so speculation cannot change any architectural state. A decode stall freezes fetch, but a taken redirect overrides it. A counter records every cycle lost to branches.

Top module: `bfc_fetch_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, the decode valid bit is 0, the decode word is zero, the penalty counter is 0 and the memory address is 0. The first valid instruction delivered comes from address 0.
- R2: The memory address output is the fetch address for the next cycle, and its data is expected on the read input one cycle later. With no branches and no stalls, decode receives the words at consecutive addresses, 4 bytes apart, one per cycle, each with its own address.
- R3: A decode word counts as a branch only when it is valid and its bits [6:0] equal the parameter BR_OPCODE (default 7'h63). For any other word, the resolve strobe and the taken flag are ignored.
- R4: A branch resolved taken, in either policy, places exactly one bubble in decode. The next valid instruction is the word at the resolved target.
- R5: In the predict-not-taken policy (policy input = 1), a branch resolved untaken is followed directly in the next cycle by its fall-through instruction, with no bubble.
- R6: In the freeze policy (policy input = 0), a branch resolved untaken is followed by exactly one bubble and then its fall-through instruction. The word fetched while the branch was in decode is never presented.
- R7: Whenever the decode valid bit is 0, the decode word is all zero.
- R8: While the stall input is 1, the decode outputs and the fetch address hold. The exception is a taken branch resolved in that same cycle, which redirects fetch anyway.
- R9: A valid branch in decode without the resolve strobe holds fetch and decode, in the same way as a stall.
- R10: The penalty counter rises by exactly one for each bubble a branch causes. It does not change in any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policy_i | input | 1 | 1 = predict-not-taken, 0 = freeze |
| stall_i | input | 1 | Decode stall request |
| br_resolve_i | input | 1 | Decode has resolved the branch now in decode |
| br_taken_i | input | 1 | Resolved branch is taken |
| br_target_i | input | AW | Resolved branch target address |
| imem_addr_o | output | AW | Address presented to instruction memory |
| imem_rdata_i | input | IW | Instruction word read one cycle after its address |
| ifid_instr_o | output | IW | Instruction word in decode |
| ifid_pc_o | output | AW | Address of the instruction in decode |
| ifid_valid_o | output | 1 | Decode instruction is valid |
| penalty_cnt_o | output | CW | Count of cycles lost to branches |

## Verification
The stall and a taken redirect can fall in the same cycle, and the redirect must win. A stall on an untaken branch must instead hold the branch so that it is resolved again. The bench raises stalls from a pseudo-random sequence while its decode model resolves every branch it sees, so both collisions arise on many branches in both policies. It also withholds resolution now and then, and sends false resolve pulses on non-branch words. A scoreboard compares the delivered instruction stream with the walked program path, and the count of unstalled bubbles is compared with the penalty counter.

// File: rtl/bfc_pkg.sv
package bfc_pkg;

  typedef enum logic [1:0] {
    ACT_ADVANCE  = 2'd0,
    ACT_HOLD     = 2'd1,
    ACT_REFETCH  = 2'd2,
    ACT_REDIRECT = 2'd3
  } fetch_act_e;

  localparam logic POLICY_FREEZE = 1'b0;
  localparam logic POLICY_PNT    = 1'b1;

endpackage

// File: rtl/bfc_pc_gen.sv
module bfc_pc_gen #(
  parameter int AW = 16,
  parameter int STEP = 4,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  bfc_pkg::fetch_act_e  act,
  input  logic [AW-1:0]        target,
  output logic [AW-1:0]        fetch_pc,
  output logic                 live,
  output logic [AW-1:0]        nxt_pc
);
  import bfc_pkg::*;

  function automatic logic [AW-1:0] seq_pc(input logic [AW-1:0] p);
    return p + AW'(STEP);
  endfunction

  always_comb begin
    case (act)
      ACT_ADVANCE:  nxt_pc = live ? seq_pc(fetch_pc) : fetch_pc;
      ACT_REDIRECT: nxt_pc = target;
      default:      nxt_pc = fetch_pc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_pc <= RESET_PC;
      live     <= 1'b0;
    end else begin
      fetch_pc <= nxt_pc;
      live     <= 1'b1;
    end
  end

endmodule

// File: rtl/bfc_ifid_reg.sv
module bfc_ifid_reg #(
  parameter int AW = 16,
  parameter int IW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  bfc_pkg::fetch_act_e  act,
  input  logic                 live,
  input  logic [AW-1:0]        fetch_pc,
  input  logic [IW-1:0]        rdata,
  output logic [IW-1:0]        instr_q,
  output logic [AW-1:0]        pc_q,
  output logic                 valid_q
);
  import bfc_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      instr_q <= '0;
      pc_q    <= '0;
      valid_q <= 1'b0;
    end else begin
      case (act)
        ACT_HOLD: begin
          instr_q <= instr_q;
          pc_q    <= pc_q;
          valid_q <= valid_q;
        end
        ACT_ADVANCE: begin
          instr_q <= live ? rdata : '0;
          pc_q    <= live ? fetch_pc : '0;
          valid_q <= live;
        end
        default: begin
          instr_q <= '0;
          pc_q    <= '0;
          valid_q <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/bfc_penalty_ctr.sv
module bfc_penalty_ctr #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bump,
  output logic [CW-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (bump) cnt <= cnt + CW'(1);
  end

endmodule

// File: rtl/bfc_fetch_ctrl.sv
module bfc_fetch_ctrl #(
  parameter int AW = 16,
  parameter int IW = 32,
  parameter int CW = 16,
  parameter int OPC_W = 7,
  parameter logic [OPC_W-1:0] BR_OPCODE = 7'h63,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          policy_i,
  input  logic          stall_i,
  input  logic          br_resolve_i,
  input  logic          br_taken_i,
  input  logic [AW-1:0] br_target_i,
  output logic [AW-1:0] imem_addr_o,
  input  logic [IW-1:0] imem_rdata_i,
  output logic [IW-1:0] ifid_instr_o,
  output logic [AW-1:0] ifid_pc_o,
  output logic          ifid_valid_o,
  output logic [CW-1:0] penalty_cnt_o
);
  import bfc_pkg::*;

  function automatic logic is_branch_op(input logic [IW-1:0] w);
    return w[OPC_W-1:0] == BR_OPCODE;
  endfunction

  logic [AW-1:0] fetch_pc;
  logic          fetch_live;
  logic          id_branch;
  logic          resolved_w;
  logic          redirect_w;
  logic          unresolved_w;
  logic          hold_w;
  logic          freeze_gap_w;
  logic          bump_w;
  fetch_act_e    act;

  assign id_branch    = ifid_valid_o && is_branch_op(ifid_instr_o);
  assign resolved_w   = id_branch && br_resolve_i;
  assign redirect_w   = resolved_w && br_taken_i;
  assign unresolved_w = id_branch && !br_resolve_i;
  assign hold_w       = stall_i || unresolved_w;
  assign freeze_gap_w = resolved_w && !br_taken_i && !stall_i &&
                        (policy_i == POLICY_FREEZE);
  assign bump_w       = redirect_w || freeze_gap_w;

  always_comb begin
    if (redirect_w)        act = ACT_REDIRECT;
    else if (hold_w)       act = ACT_HOLD;
    else if (freeze_gap_w) act = ACT_REFETCH;
    else                   act = ACT_ADVANCE;
  end

  bfc_pc_gen #(.AW(AW), .STEP(STEP), .RESET_PC('0)) u_pc (
    .clk      (clk),
    .rst_n    (rst_n),
    .act      (act),
    .target   (br_target_i),
    .fetch_pc (fetch_pc),
    .live     (fetch_live),
    .nxt_pc   (imem_addr_o)
  );

  bfc_ifid_reg #(.AW(AW), .IW(IW)) u_ifid (
    .clk      (clk),
    .rst_n    (rst_n),
    .act      (act),
    .live     (fetch_live),
    .fetch_pc (fetch_pc),
    .rdata    (imem_rdata_i),
    .instr_q  (ifid_instr_o),
    .pc_q     (ifid_pc_o),
    .valid_q  (ifid_valid_o)
  );

  bfc_penalty_ctr #(.CW(CW)) u_pen (
    .clk   (clk),
    .rst_n (rst_n),
    .bump  (bump_w),
    .cnt   (penalty_cnt_o)
  );

endmodule

// File: rtl/bfc_fetch_ctrl_chk.sv
module bfc_fetch_ctrl_chk #(
  parameter int AW = 16,
  parameter int IW = 32,
  parameter int CW = 16,
  parameter int OPC_W = 7,
  parameter logic [OPC_W-1:0] BR_OPCODE = 7'h63
) (
  input logic          clk,
  input logic          rst_n,
  input logic          policy_i,
  input logic          stall_i,
  input logic          br_resolve_i,
  input logic          br_taken_i,
  input logic [AW-1:0] br_target_i,
  input logic [IW-1:0] ifid_instr_o,
  input logic [AW-1:0] ifid_pc_o,
  input logic          ifid_valid_o,
  input logic [CW-1:0] penalty_cnt_o,
  input logic [AW-1:0] fetch_pc,
  input logic          redirect_w,
  input logic          freeze_gap_w
);

  logic br_in_id;
  logic untaken_go;
  assign br_in_id   = ifid_valid_o && (ifid_instr_o[OPC_W-1:0] == BR_OPCODE);
  assign untaken_go = br_in_id && br_resolve_i && !br_taken_i && !stall_i;

  AST_BUBBLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !ifid_valid_o |-> ifid_instr_o == '0); // R7

  AST_REDIRECT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_w |=> !ifid_valid_o && fetch_pc == $past(br_target_i)); // R4

  AST_PNT_NO_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    (policy_i && untaken_go) |=> ifid_valid_o); // R5

  AST_FREEZE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!policy_i && untaken_go) |=> !ifid_valid_o); // R6

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_i && !redirect_w) |=> $stable(ifid_instr_o) && $stable(ifid_valid_o)
                                 && $stable(ifid_pc_o) && $stable(fetch_pc)); // R8

  AST_UNRESOLVED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (br_in_id && !br_resolve_i) |=> $stable(ifid_instr_o) && $stable(ifid_pc_o)); // R9

  AST_PENALTY_BUMP: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_w || freeze_gap_w) |=> penalty_cnt_o == $past(penalty_cnt_o) + CW'(1)); // R10

  AST_PENALTY_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
    !(redirect_w || freeze_gap_w) |=> $stable(penalty_cnt_o)); // R10

endmodule

bind bfc_fetch_ctrl bfc_fetch_ctrl_chk #(
  .AW(AW), .IW(IW), .CW(CW), .OPC_W(OPC_W), .BR_OPCODE(BR_OPCODE)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .policy_i      (policy_i),
  .stall_i       (stall_i),
  .br_resolve_i  (br_resolve_i),
  .br_taken_i    (br_taken_i),
  .br_target_i   (br_target_i),
  .ifid_instr_o  (ifid_instr_o),
  .ifid_pc_o     (ifid_pc_o),
  .ifid_valid_o  (ifid_valid_o),
  .penalty_cnt_o (penalty_cnt_o),
  .fetch_pc      (fetch_pc),
  .redirect_w    (redirect_w),
  .freeze_gap_w  (freeze_gap_w)
);

// File: tb/bfc_fetch_ctrl_test.sv
module bfc_fetch_ctrl_test;

  localparam int AW = 16;
  localparam int IW = 32;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          policy_i = 1'b0;
  logic          stall_i = 1'b0;
  logic          br_resolve_i = 1'b0;
  logic          br_taken_i = 1'b0;
  logic [AW-1:0] br_target_i = '0;
  logic [AW-1:0] imem_addr_o;
  logic [IW-1:0] imem_rdata_i = '0;
  logic [IW-1:0] ifid_instr_o;
  logic [AW-1:0] ifid_pc_o;
  logic          ifid_valid_o;
  logic [CW-1:0] penalty_cnt_o;

  int checks = 0;
  int fails = 0;

  typedef struct {
    logic [AW-1:0] pc;
    logic [IW-1:0] ins;
  } item_t;
  item_t sb_q[$];
  int exp_pen;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  bfc_fetch_ctrl uut (
    .clk(clk), .rst_n(rst_n), .policy_i(policy_i), .stall_i(stall_i),
    .br_resolve_i(br_resolve_i), .br_taken_i(br_taken_i), .br_target_i(br_target_i),
    .imem_addr_o(imem_addr_o), .imem_rdata_i(imem_rdata_i),
    .ifid_instr_o(ifid_instr_o), .ifid_pc_o(ifid_pc_o), .ifid_valid_o(ifid_valid_o),
    .penalty_cnt_o(penalty_cnt_o)
  );

  // Program: every fifth word is a branch; bit 7 = taken, [25:16] = target word index
  function automatic logic [IW-1:0] prog(input int idx);
    int t;
    if (idx % 5 == 3) begin
      t = (idx * 7 + 2) % 64;
      return {6'd0, 10'(t), 8'd0, (idx % 3 == 1), 7'h63};
    end
    return {8'hA5, 8'(idx), 9'd0, 7'h13};
  endfunction

  always @(posedge clk) imem_rdata_i <= prog(int'(imem_addr_o[7:2]));

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // Driver: walk the program path and push the expected decode stream
  task automatic load_expect(input bit pnt, input int n);
    logic [AW-1:0] pc;
    logic [IW-1:0] w;
    item_t it;
    pc = '0;
    exp_pen = 0;
    sb_q.delete();
    for (int i = 0; i < n; i++) begin
      w = prog(int'(pc[7:2]));
      it.pc = pc;
      it.ins = w;
      sb_q.push_back(it);
      if (w[6:0] == 7'h63) begin
        if (w[7]) begin
          if (i < n - 1) exp_pen++;
          pc = {4'd0, w[25:16], 2'b00};
        end else begin
          if (!pnt && i < n - 1) exp_pen++;
          pc = pc + 16'd4;
        end
      end else pc = pc + 16'd4;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    stall_i = 1'b0;
    br_resolve_i = 1'b0;
    br_taken_i = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(ifid_valid_o == 1'b0, "R1 valid in reset", 64'(ifid_valid_o), 64'd0);
    chk(ifid_instr_o == '0, "R1 instr in reset", 64'(ifid_instr_o), 64'd0);
    chk(penalty_cnt_o == '0, "R1 penalty in reset", 64'(penalty_cnt_o), 64'd0);
    chk(imem_addr_o == '0, "R1 address in reset", 64'(imem_addr_o), 64'd0);
    rst_n = 1'b1;
  endtask

  // Decode model plus monitor, one step per cycle at the falling edge
  task automatic run_phase(input bit pnt, input bit stress, input int n, input string tag);
    bit first_seen;
    bit done;
    int bubbles;
    int cyc;
    bit isbr, withhold, spur, redir, held;
    item_t it;
    policy_i = pnt;
    load_expect(pnt, n);
    do_reset();
    first_seen = 0;
    done = 0;
    bubbles = 0;
    cyc = 0;
    while (!done) begin
      @(negedge clk);
      cyc++;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      isbr = ifid_valid_o && (ifid_instr_o[6:0] == 7'h63);
      withhold = stress && isbr && lfsr[3] && lfsr[7];
      spur = stress && !isbr && lfsr[5];
      stall_i = stress && lfsr[0] && lfsr[2];
      br_resolve_i = isbr ? !withhold : spur;
      br_taken_i = isbr ? ifid_instr_o[7] : spur;
      br_target_i = isbr ? {4'd0, ifid_instr_o[25:16], 2'b00} : 16'h0040;
      redir = isbr && !withhold && ifid_instr_o[7];
      held = (stall_i || (isbr && withhold)) && !redir;
      if (!ifid_valid_o)
        chk(ifid_instr_o == '0, "R7 bubble word", 64'(ifid_instr_o), 64'd0);
      if (ifid_valid_o && !held) begin
        it = sb_q.pop_front();
        if (!first_seen)
          chk(ifid_pc_o == '0, "R1 first address", 64'(ifid_pc_o), 64'd0);
        first_seen = 1;
        chk(ifid_pc_o == it.pc, {tag, " address"}, 64'(ifid_pc_o), 64'(it.pc));
        chk(ifid_instr_o == it.ins, {tag, " word"}, 64'(ifid_instr_o), 64'(it.ins));
        if (sb_q.size() == 0) begin
          chk(penalty_cnt_o == CW'(exp_pen), "R10 penalty count", 64'(penalty_cnt_o), 64'(exp_pen));
          chk(bubbles == exp_pen, {tag, " bubble count"}, 64'(bubbles), 64'(exp_pen));
          done = 1;
        end
      end else if (first_seen && !ifid_valid_o && !stall_i) begin
        bubbles++;
      end
      if (cyc > 5000) begin
        chk(1'b0, {tag, " watchdog expired"}, 64'(cyc), 64'd5000);
        done = 1;
      end
    end
    stall_i = 1'b0;
    br_resolve_i = 1'b0;
    br_taken_i = 1'b0;
  endtask

  initial begin
    run_phase(1'b1, 1'b0, 40, "R2/R4/R5 predict-not-taken");
    run_phase(1'b0, 1'b0, 40, "R2/R4/R6 freeze");
    run_phase(1'b1, 1'b1, 80, "R3/R8/R9/R4/R5 stressed predict-not-taken");
    run_phase(1'b0, 1'b1, 80, "R3/R8/R9/R4/R6 stressed freeze");
    do_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule